// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block connects a single-outstanding request/acknowledge port inside a synchronous design to an external asynchronous static RAM of 128K bytes. It turns each request into a timed sequence on the memory pins. Those pins are a 17-bit address, an active-low select and an active-high select, an active-low output enable, an active-low write enable, and an 8-bit data bus. The data bus is carried as separate output-data, driver-enable and input-data signals, so the bidirectional pad sits outside the block.

Every phase of an access lasts a whole number of clock cycles. At elaboration time each count is the ceiling of a nanosecond minimum divided by the clock period parameter, and never less than one cycle. A speed-grade parameter picks either the 55 ns or the 70 ns timing set. A read holds the address, select and output enable for the full access window. The byte is captured on the last edge of that window. The selects are then held off for the bus-release time. A write presents the address and select one cycle before the write strobe falls. The block drives data only while the strobe is low and keeps the select on for one cycle after the strobe rises.

Top module: `sram_async_ctrl`

## Requirements
- R1: During reset and whenever the port is idle (`req_ready` high), the low-active select is high, the high-active select is low, output enable and write enable are high, and the data drivers are off.
- R2: A read holds both selects active, output enable low and write enable high for at least RD_CYC cycles. RD_CYC is the ceiling of max(read cycle, address access) over the clock period: 55 ns, or 70 ns in the slow grade, which is 14 cycles at 4 ns. The byte returned is the one sampled on the final edge of that window.
- R3: A write holds write enable low for at least WR_CYC cycles. WR_CYC is the ceiling of max(write pulse, address-to-end, select-to-end) over the period: 45 ns, or 60 ns slow, which is 12 cycles at 4 ns. Both selects are active in the cycle after write enable rises.
- R4: The data drivers are enabled only while write enable is low, and the byte written is the byte given with the request.
- R5: Output enable and write enable are never low in the same cycle.
- R6: After a read, both selects stay inactive for at least HZ_CYC cycles before the next access begins. HZ_CYC is the ceiling of the release time over the period: 20 ns, or 25 ns slow, which is 5 cycles at 4 ns.
- R7: The address does not change while the memory is selected.
- R8: A request is taken only while `req_ready` is high. A request presented while busy is ignored. `ack` is high for exactly one cycle per access, and `rd_data` is valid while `ack` is high.
- R9: A read returns the last byte written to that address, including at addresses 0 and 0x1FFFF.
- R10: A zero clock period, a speed grade other than 0 or 1, or a grade whose data-setup time exceeds its write pulse is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | High when a request can be taken |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte returned by the last read |
| mem_addr | output | 17 | Memory address pins |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel | output | 1 | Active-high memory select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Driver enable for the data pad |
| mem_dq_in | input | 8 | Data arriving from the memory pad |

## Verification
The assertions assume that the clock period parameter matches the real clock. They also assume that `mem_dq_in` is only meaningful once the memory's access time has passed. The bench's memory model enforces this by returning a poison byte (0xA5) until output enable has been low for 14 cycles. It writes into its array only when write enable rises. Request data and the model's default contents are chosen never to equal the poison byte, so a read captured too early shows up as a mismatch. The bench drives requests only on falling edges, and each request is held for exactly one accepting edge except in the deliberate busy-time request test.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_READ  = 3'd1,
      PH_TURN  = 3'd2,
      PH_WSET  = 3'd3,
      PH_WPUL  = 3'd4,
      PH_WREC  = 3'd5
   } phase_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // ceiling of ns / period, floor of one cycle
   function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
      int unsigned c;
      c = (per == 0) ? 1 : (ns + per - 1) / per;
      return (c == 0) ? 1 : c;
   endfunction

   // grade 0: 55 ns bin, grade 1: 70 ns bin
   function automatic int unsigned t_read_ns(input int unsigned g);
      int unsigned trc, taa;
      trc = (g == 1) ? 70 : 55;
      taa = (g == 1) ? 70 : 55;
      return max2(trc, taa);
   endfunction

   function automatic int unsigned t_write_ns(input int unsigned g);
      int unsigned twp, taw, tcw;
      twp = (g == 1) ? 50 : 40;
      taw = (g == 1) ? 60 : 45;
      tcw = (g == 1) ? 60 : 45;
      return max2(twp, max2(taw, tcw));
   endfunction

   function automatic int unsigned t_release_ns(input int unsigned g);
      return (g == 1) ? 25 : 20;
   endfunction

   function automatic int unsigned t_dsetup_ns(input int unsigned g);
      return (g == 1) ? 25 : 20;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (load)            cnt <= load_val;
      else if (cnt != '0)       cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/sram_strobe_decode.sv
module sram_strobe_decode
   import sram_ctrl_pkg::*;
(
   input  phase_e ph,
   output logic   sel_n,
   output logic   sel,
   output logic   oe_n,
   output logic   we_n,
   output logic   dq_oe
);
   logic active;

   always_comb begin
      active = (ph == PH_READ) || (ph == PH_WSET) || (ph == PH_WPUL) || (ph == PH_WREC);
      sel_n  = !active;
      sel    = active;
      oe_n   = (ph != PH_READ);
      we_n   = (ph != PH_WPUL);
      dq_oe  = (ph == PH_WPUL);
   end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_NS = 4,
   parameter int unsigned SPEED_GRADE   = 0,
   parameter int unsigned ADDR_W        = 17,
   parameter int unsigned DATA_W        = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              ack,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_sel_n,
   output logic              mem_sel,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam int unsigned RD_CYC = ns2cyc(t_read_ns(SPEED_GRADE), CLK_PERIOD_NS);
   localparam int unsigned WR_CYC = ns2cyc(t_write_ns(SPEED_GRADE), CLK_PERIOD_NS);
   localparam int unsigned HZ_CYC = ns2cyc(t_release_ns(SPEED_GRADE), CLK_PERIOD_NS);
   localparam int unsigned MX_CYC = max2(RD_CYC, max2(WR_CYC, HZ_CYC));
   localparam int unsigned CW     = $clog2(MX_CYC + 1);

   // R10 elaboration checks
   generate
      if (CLK_PERIOD_NS == 0) begin : g_bad_period
         $error("sram_async_ctrl: CLK_PERIOD_NS must be nonzero");
      end
      if (SPEED_GRADE > 1) begin : g_bad_grade
         $error("sram_async_ctrl: SPEED_GRADE must be 0 or 1");
      end
      if (t_dsetup_ns(SPEED_GRADE) > t_write_ns(SPEED_GRADE)) begin : g_bad_setup
         $error("sram_async_ctrl: data setup exceeds write pulse");
      end
      if (ADDR_W == 0 || DATA_W == 0) begin : g_bad_width
         $error("sram_async_ctrl: zero width");
      end
   endgenerate

   phase_e              ph, ph_nxt;
   logic                t_load, t_done;
   logic [CW-1:0]       t_val;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [DATA_W-1:0]   rdata_q;
   logic                ack_q;
   logic                accept;
   logic                d_sel_n, d_sel, d_oe_n, d_we_n, d_dq_oe;

   assign accept = (ph == PH_IDLE) && req_valid;

   always_comb begin
      ph_nxt = ph;
      t_load = 1'b0;
      t_val  = '0;
      unique case (ph)
         PH_IDLE: if (req_valid) begin
            if (req_write) ph_nxt = PH_WSET;
            else begin
               ph_nxt = PH_READ;
               t_load = 1'b1;
               t_val  = CW'(RD_CYC - 1);
            end
         end
         PH_READ: if (t_done) begin
            ph_nxt = PH_TURN;
            t_load = 1'b1;
            t_val  = CW'(HZ_CYC - 1);
         end
         PH_TURN: if (t_done) ph_nxt = PH_IDLE;
         PH_WSET: begin
            ph_nxt = PH_WPUL;
            t_load = 1'b1;
            t_val  = CW'(WR_CYC - 1);
         end
         PH_WPUL: if (t_done) ph_nxt = PH_WREC;
         PH_WREC: ph_nxt = PH_IDLE;
         default: ph_nxt = PH_IDLE;
      endcase
   end

   sram_phase_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .done     (t_done)
   );

   sram_strobe_decode u_dec (
      .ph    (ph_nxt),
      .sel_n (d_sel_n),
      .sel   (d_sel),
      .oe_n  (d_oe_n),
      .we_n  (d_we_n),
      .dq_oe (d_dq_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         mem_sel_n <= 1'b1;
         mem_sel   <= 1'b0;
         mem_oe_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
         ack_q     <= 1'b0;
      end else begin
         ph        <= ph_nxt;
         mem_sel_n <= d_sel_n;
         mem_sel   <= d_sel;
         mem_oe_n  <= d_oe_n;
         mem_we_n  <= d_we_n;
         mem_dq_oe <= d_dq_oe;
         ack_q     <= ((ph == PH_READ) && t_done) || (ph == PH_WREC);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if ((ph == PH_READ) && t_done) rdata_q <= mem_dq_in;
      end
   end

   assign req_ready  = (ph == PH_IDLE);
   assign ack        = ack_q;
   assign rd_data    = rdata_q;
   assign mem_addr   = addr_q;
   assign mem_dq_out = wdata_q;
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_NS = 4,
   parameter int unsigned SPEED_GRADE   = 0,
   parameter int unsigned ADDR_W        = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_sel_n,
   input logic              mem_sel,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_dq_oe
);
   localparam logic [15:0] RD_N = 16'(ns2cyc(t_read_ns(SPEED_GRADE), CLK_PERIOD_NS));
   localparam logic [15:0] WR_N = 16'(ns2cyc(t_write_ns(SPEED_GRADE), CLK_PERIOD_NS));
   localparam logic [15:0] HZ_N = 16'(ns2cyc(t_release_ns(SPEED_GRADE), CLK_PERIOD_NS));

   logic [15:0] oe_run, we_run, idle_run;
   logic        after_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_run   <= '0;
         we_run   <= '0;
         idle_run <= '0;
         after_rd <= 1'b0;
      end else begin
         oe_run   <= !mem_oe_n  ? ((oe_run == 16'hFFFF) ? oe_run : oe_run + 1'b1) : '0;
         we_run   <= !mem_we_n  ? ((we_run == 16'hFFFF) ? we_run : we_run + 1'b1) : '0;
         idle_run <= mem_sel_n  ? ((idle_run == 16'hFFFF) ? idle_run : idle_run + 1'b1) : '0;
         if (!mem_oe_n)      after_rd <= 1'b1;
         else if (!mem_we_n) after_rd <= 1'b0;
      end
   end

   AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe)); // R1
   AST_READ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> (oe_run >= RD_N)); // R2
   AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_run >= WR_N && !mem_sel_n && mem_sel)); // R3
   AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> !mem_we_n); // R4
   AST_NO_STROBE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n)); // R5
   AST_READ_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(mem_sel_n) && after_rd) |-> (idle_run >= HZ_N)); // R6
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr)); // R7
   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack); // R8
endmodule

bind sram_async_ctrl sram_ctrl_checker #(
   .CLK_PERIOD_NS (CLK_PERIOD_NS),
   .SPEED_GRADE   (SPEED_GRADE),
   .ADDR_W        (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .ack       (ack),
   .mem_addr  (mem_addr),
   .mem_sel_n (mem_sel_n),
   .mem_sel   (mem_sel),
   .mem_oe_n  (mem_oe_n),
   .mem_we_n  (mem_we_n),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;
   localparam int RD_NEED = (55 + 3) / 4;  // 14
   localparam int WR_NEED = (45 + 3) / 4;  // 12
   localparam int HZ_NEED = (20 + 3) / 4;  // 5
   localparam logic [7:0] POISON = 8'hA5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, ack;
   logic [7:0]  rd_data;
   logic [16:0] mem_addr;
   logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [7:0]  mem_dq_out, mem_dq_in;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   sram_async_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready), .ack(ack),
      .rd_data(rd_data), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

   // ---------------- behavioural memory and timing monitor ----------------
   logic [7:0] mdl [int];
   logic [7:0] shadow [int];
   int rd_cnt = 0, we_cnt = 0, desel_cnt = 0;
   bit after_rd = 0, prev_sel = 0, prev_we_low = 0;
   bit bad_drive = 0, bad_overlap = 0, bad_addr = 0, bad_idle = 0;
   logic [16:0] prev_addr = '0, w_addr = '0;
   logic [7:0]  w_data = '0;

   function automatic logic [7:0] dflt(input logic [16:0] a);
      logic [7:0] v;
      v = a[7:0] ^ a[15:8] ^ {a[16], 7'h33};
      return (v == POISON) ? 8'h5A : v;
   endfunction

   function automatic logic [7:0] mdl_rd(input logic [16:0] a);
      return mdl.exists(int'(a)) ? mdl[int'(a)] : dflt(a);
   endfunction

   function automatic logic [7:0] exp_rd(input logic [16:0] a);
      return shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(a);
   endfunction

   wire sel_now = !mem_sel_n && mem_sel;
   assign mem_dq_in = (sel_now && !mem_oe_n && mem_we_n && rd_cnt >= RD_NEED)
                      ? mdl_rd(mem_addr) : POISON;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (rst_n) begin
      if (mem_dq_oe && mem_we_n) bad_drive = 1;                       // R4
      if (!mem_oe_n && !mem_we_n) bad_overlap = 1;                    // R5
      if (sel_now && prev_sel && mem_addr != prev_addr) bad_addr = 1; // R7
      if (req_ready && (sel_now || !mem_sel_n || !mem_oe_n || !mem_we_n || mem_dq_oe))
         bad_idle = 1;                                                // R1
      if (sel_now && !prev_sel) begin
         if (after_rd) chk(desel_cnt >= HZ_NEED, "R6 turnaround", desel_cnt, HZ_NEED);
         after_rd = 0;
      end
      if (!mem_we_n) begin
         we_cnt++;
         w_addr = mem_addr;
         if (mem_dq_oe) w_data = mem_dq_out;
      end else if (prev_we_low) begin
         chk(we_cnt >= WR_NEED, "R3 write pulse", we_cnt, WR_NEED);
         chk(sel_now, "R3 select after write", sel_now, 1);
         mdl[int'(w_addr)] = w_data;
         we_cnt = 0;
      end
      if (sel_now && !mem_oe_n && mem_we_n) begin rd_cnt++; after_rd = 1; end
      else rd_cnt = 0;
      desel_cnt = sel_now ? 0 : desel_cnt + 1;
      prev_sel = sel_now;
      prev_we_low = !mem_we_n;
      prev_addr = mem_addr;
   end

   // ---------------- stimulus ----------------
   task automatic access(input bit wr, input logic [16:0] a, input logic [7:0] d,
                         output logic [7:0] q);
      forever begin @(negedge clk); if (req_ready) break; end
      req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 0;
      chk(!req_ready, "R8 busy after accept", req_ready, 0);
      forever begin @(negedge clk); if (ack) break; end
      q = rd_data;
      @(negedge clk);
      chk(!ack, "R8 ack single cycle", ack, 0);
      if (wr) shadow[int'(a)] = d;
   endtask

   task automatic wr(input logic [16:0] a, input logic [7:0] d);
      logic [7:0] q;
      access(1, a, d, q);
   endtask

   task automatic rd_check(input logic [16:0] a, input string tag);
      logic [7:0] q, e;
      e = exp_rd(a);
      access(0, a, 8'h00, q);
      chk(q == e, tag, q, e);
   endtask

   function automatic logic [16:0] sweep_addr(input int i);
      if (i == 0) return 17'h00000;
      if (i == 1) return 17'h1FFFF;
      return 17'((i * 4093 + 77) & 17'h1FFFF);
   endfunction

   function automatic logic [7:0] sweep_data(input int i);
      logic [7:0] v;
      v = 8'((i * 37 + 11) & 8'hFF);
      return (v == POISON) ? 8'h3C : v;
   endfunction

   initial begin
      logic [7:0] q;
      repeat (3) @(negedge clk);
      chk(mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe,
          "R1 reset pins", {mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready && !ack, "R1 ready after reset", {req_ready, ack}, 2'b10);

      // untouched locations return the model's default contents (R2)
      for (int i = 40; i < 44; i++) rd_check(sweep_addr(i), "R2 default read");

      // write sweep then read back, including both address ends (R9)
      for (int i = 0; i < 32; i++) wr(sweep_addr(i), sweep_data(i));
      for (int i = 0; i < 32; i++) rd_check(sweep_addr(i), "R9 read back");

      // read immediately followed by write, then read (R6, R9)
      for (int i = 0; i < 8; i++) begin
         rd_check(sweep_addr(i), "R6 read before write");
         wr(sweep_addr(i), ~sweep_data(i) ^ 8'h01);
         rd_check(sweep_addr(i), "R9 rewrite");
      end

      // request held during a busy access is ignored (R8)
      forever begin @(negedge clk); if (req_ready) break; end
      req_valid = 1; req_write = 1; req_addr = 17'h00100; req_wdata = 8'h42;
      @(negedge clk);
      req_addr = 17'h00200; req_wdata = 8'h99;  // ignored: block is busy
      forever begin @(negedge clk); if (ack) break; end
      req_valid = 0;
      shadow[32'h100] = 8'h42;
      @(negedge clk);
      rd_check(17'h00100, "R8 accepted write");
      rd_check(17'h00200, "R8 busy request ignored");

      chk(!bad_drive, "R4 drive only with write strobe", bad_drive, 0);
      chk(!bad_overlap, "R5 strobe overlap", bad_overlap, 0);
      chk(!bad_addr, "R7 address held", bad_addr, 0);
      chk(!bad_idle, "R1 idle pins", bad_idle, 0);
      // R10 is covered by elaboration with the default grade and period
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(100000 * 4);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule